// File: doc/BRIEF.md
# Prioritized Nesting Interrupt Controller

This block gathers twelve maskable interrupt sources (five external request pins and seven internal peripheral lines: three timers, two DMA channels, the asynchronous serial port and a watchdog) together with one nonmaskable input. It picks one winner by programmable priority and offers it to a CPU through a request / acknowledge / vector handshake. The CPU sees `irq_o`, pulses `inta_i` for one cycle, and reads the type number on `vec_o` in that same cycle.

Every maskable source has a mask bit and a 3-bit priority, set through a small write port. Acknowledging a source marks it in service until software issues a specific end-of-interrupt for it. With nesting disabled, no maskable request is offered while anything is in service. With nesting enabled, only a request that strictly outranks every in-service source is offered. In slave mode an external cascaded controller is the system master, so this block withholds all maskable requests. The nonmaskable request bypasses all of these rules.

Top module: `irq_prio_ctl`

## Requirements
- R1: After reset every source is masked with priority 7, nothing is in service or pending, `irq_o` is 0 and `vec_o` is 0.
- R2: A source whose mask bit is 1 is never offered. A write with `cfg_we_i`=1 and `cfg_sel_i` below 12 loads `cfg_mask_i` and `cfg_pri_i` for that source from the next cycle on. Source indices: 0-2 timers 0-2, 3-4 DMA 0-1, 5-9 pins INT0-INT4, 10 serial port, 11 watchdog.
- R3: Among unmasked, asserted, not-in-service sources, the smallest priority value wins. Ties go to the lowest source index.
- R4: `vec_o` is nonzero only in a cycle where `inta_i` and `irq_o` are both 1. It then carries the winner's type number: timers 8, 18, 19; DMA 10, 11; INT0-INT3 12-15; INT4 17; serial 20; watchdog 16.
- R5: An acknowledge of a maskable winner sets its in-service bit at the clock edge. That source is not offered again until `eoi_we_i` with its index in `eoi_sel_i` clears the bit. A set and a clear in the same cycle leave the bit set.
- R6: With `nest_en_i`=0, no maskable request is offered while any in-service bit is set.
- R7: With `nest_en_i`=1, a maskable request is offered only if its priority value is strictly smaller than that of every in-service source.
- R8: A rising edge on `nmi_i` makes the nonmaskable request pending from the next cycle. A pending nonmaskable request is offered ahead of everything, regardless of masks, nesting or slave mode, with type number 2. Its acknowledge clears it without setting an in-service bit.
- R9: With `slave_en_i`=1, no maskable request is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 12 | Level request per maskable source |
| nmi_i | input | 1 | Nonmaskable request, edge-detected |
| nest_en_i | input | 1 | Nesting enable |
| slave_en_i | input | 1 | Slave mode: defer to external master |
| cfg_we_i | input | 1 | Mask/priority write strobe |
| cfg_sel_i | input | 4 | Source index to configure |
| cfg_mask_i | input | 1 | Mask value to write |
| cfg_pri_i | input | 3 | Priority value to write |
| eoi_we_i | input | 1 | End-of-interrupt strobe |
| eoi_sel_i | input | 4 | Source index whose in-service bit is cleared |
| inta_i | input | 1 | Acknowledge from CPU |
| irq_o | output | 1 | Interrupt request to CPU |
| vec_o | output | 8 | Type number during acknowledge, else 0 |

## Verification
A stale or stuck in-service bit shows up at the ports within one cycle: `irq_o` stays low when a request should be offered, or a nested request appears when it should not. A corrupted mask or priority register changes the winner, and that is seen as a wrong `vec_o` in the next acknowledge cycle. A lost or duplicated nonmaskable pending flag shows as a missing or repeated type 2. The bench's reference model compares `irq_o` and `vec_o` every cycle, so any divergence is reported in the cycle it appears.

// File: rtl/irq_prio_ctl.sv
module irq_prio_ctl #(
  parameter int PRI_W   = 3,
  parameter int VEC_W   = 8,
  parameter int NMI_VEC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [11:0]       req_i,
  input  logic              nmi_i,
  input  logic              nest_en_i,
  input  logic              slave_en_i,
  input  logic              cfg_we_i,
  input  logic [3:0]        cfg_sel_i,
  input  logic              cfg_mask_i,
  input  logic [PRI_W-1:0]  cfg_pri_i,
  input  logic              eoi_we_i,
  input  logic [3:0]        eoi_sel_i,
  input  logic              inta_i,
  output logic              irq_o,
  output logic [VEC_W-1:0]  vec_o
);
  localparam int NSRC  = 12;
  localparam int SEL_W = 4;
  localparam int LVL_W = PRI_W + 1;
  localparam logic [LVL_W-1:0] LVL_NONE = LVL_W'(1 << PRI_W);

  logic [NSRC-1:0]             mask_q, isr_q, cand, isr_set, isr_clr;
  logic [NSRC-1:0][PRI_W-1:0]  pri_q;
  logic                        nmi_q, nmi_pend_q;
  logic [LVL_W-1:0]            best, svc;
  logic [SEL_W-1:0]            win_idx;
  logic                        found, present_m, ack;

  function automatic logic [VEC_W-1:0] src_vec(input logic [SEL_W-1:0] idx);
    case (idx)
      4'd0:    src_vec = VEC_W'(8);
      4'd1:    src_vec = VEC_W'(18);
      4'd2:    src_vec = VEC_W'(19);
      4'd3:    src_vec = VEC_W'(10);
      4'd4:    src_vec = VEC_W'(11);
      4'd5:    src_vec = VEC_W'(12);
      4'd6:    src_vec = VEC_W'(13);
      4'd7:    src_vec = VEC_W'(14);
      4'd8:    src_vec = VEC_W'(15);
      4'd9:    src_vec = VEC_W'(17);
      4'd10:   src_vec = VEC_W'(20);
      4'd11:   src_vec = VEC_W'(16);
      default: src_vec = '0;
    endcase
  endfunction

  assign cand = req_i & ~mask_q & ~isr_q;

  always_comb begin
    best    = LVL_NONE;
    svc     = LVL_NONE;
    win_idx = '0;
    found   = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (cand[i] && ({1'b0, pri_q[i]} < best)) begin
        best    = {1'b0, pri_q[i]};
        win_idx = SEL_W'(i);
        found   = 1'b1;
      end
      if (isr_q[i] && ({1'b0, pri_q[i]} < svc))
        svc = {1'b0, pri_q[i]};
    end
  end

  assign present_m = found & ~slave_en_i & (nest_en_i ? (best < svc) : (isr_q == '0));
  assign irq_o     = nmi_pend_q | present_m;
  assign ack       = inta_i & irq_o;
  assign vec_o     = !ack ? '0 : (nmi_pend_q ? VEC_W'(NMI_VEC) : src_vec(win_idx));

  assign isr_set = (ack && !nmi_pend_q) ? (NSRC'(1) << win_idx) : '0;
  assign isr_clr = (eoi_we_i && eoi_sel_i < SEL_W'(NSRC)) ? (NSRC'(1) << eoi_sel_i) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q     <= '1;
      pri_q      <= '1;
      isr_q      <= '0;
      nmi_q      <= 1'b0;
      nmi_pend_q <= 1'b0;
    end else begin
      nmi_q <= nmi_i;
      isr_q <= (isr_q & ~isr_clr) | isr_set;
      if (cfg_we_i && cfg_sel_i < SEL_W'(NSRC)) begin
        mask_q[cfg_sel_i] <= cfg_mask_i;
        pri_q[cfg_sel_i]  <= cfg_pri_i;
      end
      if (nmi_i && !nmi_q)
        nmi_pend_q <= 1'b1;
      else if (ack && nmi_pend_q)
        nmi_pend_q <= 1'b0;
    end
  end
endmodule

module irq_prio_ctl_chk #(
  parameter int VEC_W   = 8,
  parameter int NMI_VEC = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             inta_i,
  input logic             irq_o,
  input logic [VEC_W-1:0] vec_o,
  input logic             nest_en_i,
  input logic             slave_en_i,
  input logic [11:0]      isr_q,
  input logic [11:0]      mask_q,
  input logic [3:0]       win_idx,
  input logic             nmi_pend_q
);
  a_r4_vec_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !(inta_i && irq_o) |-> vec_o == '0);
  a_r8_nmi_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_pend_q && inta_i) |-> vec_o == VEC_W'(NMI_VEC));
  a_r8_nmi_offered: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pend_q |-> irq_o);
  a_r6_no_nest_block: assert property (@(posedge clk) disable iff (!rst_n)
    (!nest_en_i && isr_q != '0 && !nmi_pend_q) |-> !irq_o);
  a_r9_slave_defers: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_en_i && !nmi_pend_q) |-> !irq_o);
  a_r2_winner_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !nmi_pend_q) |-> !mask_q[win_idx]);
  a_r5_ack_sets_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && inta_i && !nmi_pend_q) |=> isr_q != '0);
endmodule

bind irq_prio_ctl irq_prio_ctl_chk #(.VEC_W(VEC_W), .NMI_VEC(NMI_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .inta_i(inta_i), .irq_o(irq_o), .vec_o(vec_o),
  .nest_en_i(nest_en_i), .slave_en_i(slave_en_i), .isr_q(isr_q),
  .mask_q(mask_q), .win_idx(win_idx), .nmi_pend_q(nmi_pend_q));

// File: tb/tb_irq_prio_ctl.sv
module tb_irq_prio_ctl;
  logic clk = 0, rst_n = 0;
  logic [11:0] req_i = '0;
  logic nmi_i = 0, nest_en_i = 0, slave_en_i = 0;
  logic cfg_we_i = 0, cfg_mask_i = 0, eoi_we_i = 0, inta_i = 0;
  logic [3:0] cfg_sel_i = '0, eoi_sel_i = '0;
  logic [2:0] cfg_pri_i = '0;
  logic irq_o;
  logic [7:0] vec_o;

  irq_prio_ctl dut (.*);

  always #5 clk = ~clk;

  int vt [12] = '{8, 18, 19, 10, 11, 12, 13, 14, 15, 17, 20, 16};
  int m_mask [12], m_pri [12];
  bit m_isr [12];
  bit m_nq, m_np;
  int n_vec = 0, n_bad = 0;
  string phase = "R1";
  bit finished = 0;

  task automatic model_reset();
    for (int i = 0; i < 12; i++) begin m_mask[i] = 1; m_pri[i] = 7; m_isr[i] = 0; end
    m_nq = 0; m_np = 0;
  endtask

  task automatic model_eval(output bit e_irq, output int e_vec, output int w);
    int bp, svc; bit anyisr;
    bp = 99; svc = 99; w = -1; anyisr = 0;
    for (int i = 0; i < 12; i++) begin
      if (req_i[i] && !m_mask[i] && !m_isr[i] && m_pri[i] < bp) begin bp = m_pri[i]; w = i; end
      if (m_isr[i]) begin anyisr = 1; if (m_pri[i] < svc) svc = m_pri[i]; end
    end
    if (m_np) begin e_irq = 1; e_vec = inta_i ? 2 : 0; end
    else begin
      e_irq = (w >= 0) && !slave_en_i && (nest_en_i ? (bp < svc) : !anyisr);
      e_vec = (inta_i && e_irq) ? vt[w] : 0;
    end
  endtask

  task automatic step();
    bit e_irq; int e_vec, w; bit ack;
    #1;
    model_eval(e_irq, e_vec, w);
    n_vec++;
    if (irq_o !== e_irq) begin
      n_bad++;
      $display("FAIL %s irq_o actual %0b expected %0b at %0t", phase, irq_o, e_irq, $time);
    end
    if (vec_o !== 8'(e_vec)) begin
      n_bad++;
      $display("FAIL %s vec_o actual %0d expected %0d at %0t", phase, vec_o, e_vec, $time);
    end
    @(posedge clk);
    ack = inta_i && e_irq;
    if (cfg_we_i && cfg_sel_i < 12) begin m_mask[cfg_sel_i] = cfg_mask_i; m_pri[cfg_sel_i] = cfg_pri_i; end
    if (eoi_we_i && eoi_sel_i < 12) m_isr[eoi_sel_i] = 0;
    if (ack && !m_np) m_isr[w] = 1;
    if (nmi_i && !m_nq) m_np = 1;
    else if (ack && m_np) m_np = 0;
    m_nq = nmi_i;
    @(negedge clk);
  endtask

  task automatic cfg(input int s, input bit m, input int p);
    cfg_we_i = 1; cfg_sel_i = 4'(s); cfg_mask_i = m; cfg_pri_i = 3'(p);
    step(); cfg_we_i = 0;
  endtask
  task automatic ack1(); inta_i = 1; step(); inta_i = 0; endtask
  task automatic eoi(input int s); eoi_we_i = 1; eoi_sel_i = 4'(s); step(); eoi_we_i = 0; endtask

  initial begin
    #1000000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    @(negedge clk); @(negedge clk);
    phase = "R1";
    n_vec++;
    if (irq_o !== 0 || vec_o !== 0) begin
      n_bad++; $display("FAIL R1 in reset irq %0b vec %0d expected 0 0", irq_o, vec_o);
    end
    rst_n = 1;
    req_i = '1; step(); step();
    phase = "R2"; inta_i = 1; step(); inta_i = 0;
    cfg(0, 0, 5); step();
    phase = "R4"; ack1();
    phase = "R5"; step(); step();
    phase = "R6"; cfg(5, 0, 1); step();
    phase = "R7"; nest_en_i = 1; step(); ack1(); step();
    cfg(1, 0, 1); step(); step();
    phase = "R5"; eoi(5); step(); ack1(); eoi(0); eoi(1); step();
    phase = "R3"; req_i = '0;
    cfg(3, 0, 2); cfg(6, 0, 2); cfg(5, 1, 1); cfg(0, 1, 5); cfg(1, 1, 1);
    req_i = 12'b0000_0100_1000; step(); ack1(); step(); eoi(3); step();
    phase = "R8"; slave_en_i = 1; nest_en_i = 0; cfg(10, 1, 0); req_i = '1;
    nmi_i = 1; step(); step(); ack1(); nmi_i = 0; step(); step();
    phase = "R9"; step(); slave_en_i = 0; step(); ack1(); step();
    phase = "R3";
    for (int k = 0; k < 3000; k++) begin
      req_i     = 12'($urandom);
      inta_i    = ($urandom % 10) < 3;
      eoi_we_i  = ($urandom % 10) == 0;
      eoi_sel_i = 4'($urandom % 14);
      cfg_we_i  = ($urandom % 20) == 0;
      cfg_sel_i = 4'($urandom % 14);
      cfg_mask_i = ($urandom % 4) == 0;
      cfg_pri_i = 3'($urandom);
      nmi_i     = ($urandom % 40) == 0;
      if (($urandom % 100) == 0) nest_en_i = ~nest_en_i;
      if (($urandom % 150) == 0) slave_en_i = ~slave_en_i;
      step();
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule